// File: doc/BRIEF.md
# UART Auto-Baud Bit-Time Detector

This block measures the bit period of an incoming serial line while a calibration character of value 0x55 is being received. With that value, sent LSB first after a low start bit, the line changes level on every bit. Falling edges therefore arrive every two bit times. The block counts timing-clock enables between consecutive falling edges. After each such span it publishes a per-bit interval and raises a completion flag. After the fourth span, which covers data bits 5 and 6, it loads a bit-period divider with the average single-bit time and drops its own busy/enable state.

Software starts a detection with a one-cycle start command. The receive line must already be synchronized, and the timing enable must already be selected (from the protocol clock or the divided clock) by the surrounding logic. The span counter saturates instead of wrapping. A span that reaches saturation raises an overrun error in the same cycle as the completion flag. The flags and the interval have clear strobes that model the register write side.

Top module: `uart_autobaud`

## Requirements
- R1: While reset is active (rst_ni low) and after release, busy_o, done_o, err_o and irq_o are 0, and interval_o and divider_o are 0.
- R2: A start_i pulse while idle makes busy_o 1 from the next cycle. While idle, falling edges of rx_i set no flag and change neither interval_o nor divider_o.
- R3: A falling edge is a cycle where rx_i is 0 and was 1 in the previous cycle. The span of a measurement is the number of cycles with tick_i high, counted from the cycle after the previous falling edge up to and including the cycle of the current one. The first falling edge after start only begins timing.
- R4: Each of the next four falling edges sets done_o and loads interval_o with span/2 (rounded down), limited to 511. So done_o can be set four times in one character.
- R5: On the fourth measured falling edge, divider_o is loaded with span/2 (rounded down, 10 bits) and busy_o returns to 0. divider_o changes at no other time.
- R6: The span counter stops at 2047 instead of wrapping. A measurement whose span reaches 2047 sets err_o in the same cycle that it sets done_o.
- R7: clr_done_i clears done_o and err_o. clr_err_i clears err_o only. A measurement in the same cycle wins over either clear.
- R8: clr_intv_i clears interval_o to 0. A measurement in the same cycle wins.
- R9: irq_o is high exactly when done_o is high and irq_en_i is high.
- R10: Cycles with tick_i low do not advance the span counter. A character received with tick_i held low yields interval 0 and divider 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Synchronized receive line |
| tick_i | input | 1 | Timing-count enable |
| start_i | input | 1 | Start detection (one-cycle pulse) |
| clr_done_i | input | 1 | Clear completion flag and error |
| clr_err_i | input | 1 | Clear error only |
| clr_intv_i | input | 1 | Clear interval value |
| irq_en_i | input | 1 | Interrupt enable |
| busy_o | output | 1 | Detection enabled / in progress |
| done_o | output | 1 | Completion flag |
| err_o | output | 1 | Counter overrun error |
| irq_o | output | 1 | Interrupt request |
| interval_o | output | 9 | Last per-bit interval |
| divider_o | output | 10 | Derived bit-period divider |

## Verification
On every cycle, the assertions check the following: the counter saturation hold, the freeze of the counter when tick_i is low, that err_o never rises without done_o, and that done_o rises only while busy. They also check that divider_o moves only as busy_o falls, and that a lone interval clear takes effect. Only the bench scenarios show the measured values themselves. These include the span arithmetic under different tick rates, the count of four completions per character, the saturated interval and divider on a slow line, and that edges are ignored while idle.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [1:0] {
    ABD_IDLE = 2'd0,
    ABD_WAIT = 2'd1,
    ABD_MEAS = 2'd2
  } abd_state_e;
endpackage

// File: rtl/abd_fall_det.sv
module abd_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  assign fall_o = rx_q & ~rx_i;
endmodule

// File: rtl/abd_span_cnt.sv
module abd_span_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] span_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_d;

  always_comb begin
    cnt_inc = cnt_q;
    if (tick_i && (cnt_q != CNT_MAX)) cnt_inc = cnt_q + 1'b1;
    cnt_d = clear_i ? '0 : cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign span_o = cnt_inc;
  assign sat_o  = (cnt_inc == CNT_MAX);

  // R6: saturated counter holds its value
  a_r6_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) && !clear_i |=> (cnt_q == CNT_MAX));
  // R10: no tick, no advance
  a_r10_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clear_i |=> $stable(cnt_q));
endmodule

// File: rtl/abd_seq.sv
module abd_seq
  import abd_pkg::*;
#(
  parameter int N_MEAS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fall_i,
  output logic busy_o,
  output logic timing_o,
  output logic meas_o,
  output logic last_o
);
  localparam int EC_W = (N_MEAS > 1) ? $clog2(N_MEAS) : 1;
  localparam logic [EC_W-1:0] EC_LAST = EC_W'(N_MEAS - 1);

  abd_state_e      st_q, st_d;
  logic [EC_W-1:0] ec_q, ec_d;

  always_comb begin
    st_d   = st_q;
    ec_d   = ec_q;
    meas_o = 1'b0;
    last_o = 1'b0;
    case (st_q)
      ABD_IDLE: if (start_i) st_d = ABD_WAIT;
      ABD_WAIT: if (fall_i) begin
        st_d = ABD_MEAS;
        ec_d = '0;
      end
      ABD_MEAS: if (fall_i) begin
        meas_o = 1'b1;
        if (ec_q == EC_LAST) begin
          last_o = 1'b1;
          st_d   = ABD_IDLE;
        end else begin
          ec_d = ec_q + 1'b1;
        end
      end
      default: st_d = ABD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ABD_IDLE;
      ec_q <= '0;
    end else begin
      st_q <= st_d;
      ec_q <= ec_d;
    end
  end

  assign busy_o   = (st_q != ABD_IDLE);
  assign timing_o = (st_q == ABD_MEAS);

  // R2: start from idle arms the detector
  a_r2_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o);
endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud #(
  parameter int DIV_W  = 10,
  parameter int INTV_W = 9,
  parameter int N_MEAS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              clr_done_i,
  input  logic              clr_err_i,
  input  logic              clr_intv_i,
  input  logic              irq_en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              irq_o,
  output logic [INTV_W-1:0] interval_o,
  output logic [DIV_W-1:0]  divider_o
);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] INTV_LIM = DIV_W'((1 << INTV_W) - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic             fall, timing, meas, last, sat;
  logic [CNT_W-1:0] span;
  logic [DIV_W-1:0] per_bit;
  logic [INTV_W-1:0] intv_val;

  abd_fall_det u_fall (
    .clk_i (clk_i), .rst_ni(rst_n), .rx_i(rx_i), .fall_o(fall)
  );

  abd_seq #(.N_MEAS(N_MEAS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_n), .start_i(start_i), .fall_i(fall),
    .busy_o(busy_o), .timing_o(timing), .meas_o(meas), .last_o(last)
  );

  abd_span_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick_i),
    .clear_i(fall | ~timing), .span_o(span), .sat_o(sat)
  );

  // average over two bits: halve, rounding down
  assign per_bit  = span[CNT_W-1:1];
  assign intv_val = (per_bit > INTV_LIM) ? INTV_LIM[INTV_W-1:0] : per_bit[INTV_W-1:0];

  logic              done_q, done_d, err_q, err_d;
  logic [INTV_W-1:0] intv_q, intv_d;
  logic [DIV_W-1:0]  div_q, div_d;

  always_comb begin
    done_d = done_q;
    err_d  = err_q;
    intv_d = intv_q;
    div_d  = div_q;
    if (meas)            done_d = 1'b1;
    else if (clr_done_i) done_d = 1'b0;
    if (meas && sat)                    err_d = 1'b1;
    else if (clr_done_i || clr_err_i)   err_d = 1'b0;
    if (meas)            intv_d = intv_val;
    else if (clr_intv_i) intv_d = '0;
    if (last)            div_d = per_bit;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      intv_q <= '0;
      div_q  <= '0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      intv_q <= intv_d;
      div_q  <= div_d;
    end
  end

  assign done_o     = done_q;
  assign err_o      = err_q;
  assign irq_o      = done_q & irq_en_i;
  assign interval_o = intv_q;
  assign divider_o  = div_q;

  // R6: error never rises without completion
  a_r6_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(err_q) |-> done_q);
  // R4: completion only comes from an active detection
  a_r4_done_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_o));
  // R5: divider moves only as detection ends
  a_r5_div_at_end: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(div_q) |-> $fell(busy_o));
  // R8: lone interval clear takes effect
  a_r8_intv_clear: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_intv_i && !meas |=> (intv_q == '0));
endmodule

// File: tb/uart_autobaud_tb.sv
module uart_autobaud_tb;
  logic clk = 1'b0;
  logic rst_n, rx, tick, start, clr_done, clr_err, clr_intv, irq_en;
  logic busy, done, err, irq;
  logic [8:0] intv;
  logic [9:0] div;

  int checks = 0, errors = 0, ndone = 0;
  bit autoclr = 1'b1;

  always #5 clk = ~clk;

  uart_autobaud u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick), .start_i(start),
    .clr_done_i(clr_done), .clr_err_i(clr_err), .clr_intv_i(clr_intv),
    .irq_en_i(irq_en), .busy_o(busy), .done_o(done), .err_o(err), .irq_o(irq),
    .interval_o(intv), .divider_o(div)
  );

  // columns: bit period, tick every K cycles, interval, divider, err, autoclear
  localparam int NV = 5;
  localparam int VEC [NV][6] = '{
    '{   8, 1,   8,    8, 0, 1},
    '{  20, 4,   5,    5, 0, 1},
    '{  36, 3,  12,   12, 0, 1},
    '{ 600, 1, 511,  600, 0, 1},
    '{1100, 1, 511, 1023, 1, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic t);
    @(negedge clk);
    if (autoclr && done) begin
      ndone++;
      clr_done = 1'b1;
    end else clr_done = 1'b0;
    rx = r;
    tick = t;
  endtask

  task automatic send_char(input int p, input int k);
    for (int b = 0; b < 10; b++) begin
      logic v;
      if (b == 0)      v = 1'b0;
      else if (b == 9) v = 1'b1;
      else             v = logic'((8'h55 >> (b - 1)) & 1);
      for (int i = 0; i < p; i++) cyc(v, (k != 0) && ((i % k) == 0));
    end
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1);
  endtask

  task automatic do_start();
    @(negedge clk);
    clr_done = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx = 1'b1; tick = 1'b0; start = 1'b0;
    clr_done = 1'b0; clr_err = 1'b0; clr_intv = 1'b0; irq_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 err in reset", err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 interval after reset", intv, 0);
    chk("R1 divider after reset", div, 0);
    chk("R1 irq after reset", irq, 0);

    // table walk: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      autoclr = VEC[v][5] != 0;
      ndone = 0;
      do_start();
      chk("R2 busy after start", busy, 1);
      send_char(VEC[v][0], VEC[v][1]);
      chk("R4 interval", intv, VEC[v][2]);
      chk("R5 divider", div, VEC[v][3]);
      chk("R6 overrun error", err, VEC[v][4]);
      chk("R5 busy cleared", busy, 0);
      if (autoclr) chk("R4 four completions", ndone, 4);
      else         chk("R6 done with error", done, 1);
    end

    // R9 interrupt gating
    chk("R9 irq disabled", irq, 0);
    @(negedge clk); irq_en = 1'b1; #1;
    chk("R9 irq enabled", irq, 1);
    // R7 clear behaviour
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    chk("R7 err cleared by clr_err", err, 0);
    chk("R7 done kept by clr_err", done, 1);
    @(negedge clk); clr_done = 1'b1;
    @(negedge clk); clr_done = 1'b0;
    chk("R7 done cleared", done, 0);
    chk("R9 irq follows done", irq, 0);
    // R8 interval clear
    @(negedge clk); clr_intv = 1'b1;
    @(negedge clk); clr_intv = 1'b0;
    chk("R8 interval cleared", intv, 0);

    // R2 edges ignored while idle
    autoclr = 1'b1; ndone = 0;
    send_char(8, 1);
    chk("R2 no done while idle", ndone + int'(done), 0);
    chk("R2 divider untouched while idle", div, 1023);
    chk("R2 interval untouched while idle", intv, 0);

    // R10 no ticks: zero span
    ndone = 0;
    do_start();
    send_char(8, 0);
    chk("R10 divider with no ticks", div, 0);
    chk("R10 interval with no ticks", intv, 0);
    chk("R10 completions", ndone, 4);

    finish_run();
  end
endmodule